// File: doc/BRIEF.md
# Interrupt Source Masking and Routing

This block collects a set of level-sensitive interrupt lines and combines them with a register of software-raised interrupts. Each source is then either routed to a single fast request line or, if an enable bit allows it, to a vector of normal pending requests. A downstream priority unit decides which of those pending requests to service.

Software configures the block through a simple word-addressed register port. The port has one write strobe, a byte offset, write data and read data. Reads are combinational and have no side effects. Writes take effect on the next rising clock edge. The enable and software-interrupt registers each have two write addresses: one sets bits where the data is one, and the other clears bits where the data is one. Hardware lines are registered once, so the outputs follow a change on an input one clock later.

Top module: `irq_route_top`

## Requirements
- R1: The raw status (read at byte offset 0x08) is the bitwise OR of the registered source lines and the software-interrupt register.
- R2: The pending normal-request vector `irq_pend`, also readable at offset 0x00, is raw AND enable AND NOT select.
- R3: The fast status (read at 0x04) is raw AND select, with no enable masking. `fiq_req` is high exactly when any bit of the fast status is one.
- R4: A write to 0x10 ORs the write data into the enable register. A write to 0x14 clears each enable bit where the data is one. A read at 0x10 returns the enable register.
- R5: A write to 0x18 ORs the data into the software-interrupt register. A write to 0x1C clears bits where the data is one. A read at 0x18 returns that register.
- R6: The select register is written and read directly at 0x0C. A select bit of one routes that source to the fast line.
- R7: The protection register at 0x20 stores only bit 0 of the write data. It reads back as that bit with zeros above it.
- R8: Reads at 0xFE0, 0xFE4 … 0xFFC return eight identification bytes in this order: 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Reset clears the enable, select, software-interrupt and protection registers and the registered source lines. While reset is held, both outputs are low.
- R10: Reads at unmapped offsets return zero. Writes to unmapped offsets, to the identification window and to the status offsets 0x00, 0x04 and 0x08 change no state.
- R11: A change on `src_lvl` appears on `irq_pend` and `fiq_req` one clock edge later, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Hardware interrupt levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_pend | output | 32 | Enabled, non-fast pending sources |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
The assertions check the following on every cycle:
- the set/clear read-modify-write of the enable and software registers;
- the direct loads of select and protection;
- the stability of state across ignored writes;
- the one-cycle capture of the source lines;
- that no pending normal request escapes a cleared enable bit;
- that the fast line tracks the fast status.

Only the bench's scenarios can show that the identification bytes and the unmapped reads return the right values. The same holds for the overlap of software and hardware sources in the raw status, and for the exact cycle in which a source change reaches the outputs.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned WIDX_W = 10;

    localparam logic [WIDX_W-1:0] W_IRQ_STAT = 10'h000;
    localparam logic [WIDX_W-1:0] W_FIQ_STAT = 10'h001;
    localparam logic [WIDX_W-1:0] W_RAW_STAT = 10'h002;
    localparam logic [WIDX_W-1:0] W_SELECT   = 10'h003;
    localparam logic [WIDX_W-1:0] W_EN_SET   = 10'h004;
    localparam logic [WIDX_W-1:0] W_EN_CLR   = 10'h005;
    localparam logic [WIDX_W-1:0] W_SW_SET   = 10'h006;
    localparam logic [WIDX_W-1:0] W_SW_CLR   = 10'h007;
    localparam logic [WIDX_W-1:0] W_PROT     = 10'h008;
    localparam logic [WIDX_W-1:0] W_ID_BASE  = 10'h3F8;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_SELECT,
        WOP_EN_SET,
        WOP_EN_CLR,
        WOP_SW_SET,
        WOP_SW_CLR,
        WOP_PROT
    } wop_e;

    function automatic wop_e decode_wr(input logic [WIDX_W-1:0] widx);
        wop_e op;
        case (widx)
            W_SELECT: op = WOP_SELECT;
            W_EN_SET: op = WOP_EN_SET;
            W_EN_CLR: op = WOP_EN_CLR;
            W_SW_SET: op = WOP_SW_SET;
            W_SW_CLR: op = WOP_SW_CLR;
            W_PROT:   op = WOP_PROT;
            default:  op = WOP_NONE;
        endcase
        return op;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0: b = 8'h90;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [NSRC-1:0]   wdata,
    output logic [NSRC-1:0]   src_q,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   sw_q,
    output logic [NSRC-1:0]   sel_q,
    output logic              prot_q
);

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] sw;
        logic [NSRC-1:0] sel;
        logic            prot;
    } state_t;

    state_t st_d, st_q;
    wop_e   op;

    always_comb begin
        op   = wr_en ? decode_wr(widx) : WOP_NONE;
        st_d = st_q;
        st_d.src = src_lvl;
        case (op)
            WOP_SELECT: st_d.sel  = wdata;
            WOP_EN_SET: st_d.en   = st_q.en | wdata;
            WOP_EN_CLR: st_d.en   = st_q.en & ~wdata;
            WOP_SW_SET: st_d.sw   = st_q.sw | wdata;
            WOP_SW_CLR: st_d.sw   = st_q.sw & ~wdata;
            WOP_PROT:   st_d.prot = wdata[0];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_q  = st_q.src;
    assign en_q   = st_q.en;
    assign sw_q   = st_q.sw;
    assign sel_q  = st_q.sel;
    assign prot_q = st_q.prot;

    a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_EN_SET) |=> en_q == ($past(en_q) | $past(wdata)));
    a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_EN_CLR) |=> en_q == ($past(en_q) & ~$past(wdata)));
    a_r5_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_SW_SET) |=> sw_q == ($past(sw_q) | $past(wdata)));
    a_r5_sw_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_SW_CLR) |=> sw_q == ($past(sw_q) & ~$past(wdata)));
    a_r6_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_SELECT) |=> sel_q == $past(wdata));
    a_r7_prot_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_PROT) |=> prot_q == $past(wdata[0]));
    a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (widx < W_SELECT || widx > W_PROT))
            |=> ($stable(en_q) && $stable(sw_q) && $stable(sel_q) && $stable(prot_q)));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(en_q) && $stable(sw_q) && $stable(sel_q) && $stable(prot_q)));
    a_r11_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> src_q == $past(src_lvl));
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && sw_q == '0 && sel_q == '0 && !prot_q && src_q == '0));

endmodule

// File: rtl/irq_route_sort.sv
module irq_route_sort #(
    parameter int unsigned NSRC = 32
) (
    input  logic [NSRC-1:0] src_q,
    input  logic [NSRC-1:0] sw_q,
    input  logic [NSRC-1:0] en_q,
    input  logic [NSRC-1:0] sel_q,
    output logic [NSRC-1:0] raw_stat,
    output logic [NSRC-1:0] irq_stat,
    output logic [NSRC-1:0] fiq_stat,
    output logic            fiq_any
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic active;
        assign active      = src_q[i] | sw_q[i];
        assign raw_stat[i] = active;
        assign fiq_stat[i] = active & sel_q[i];
        assign irq_stat[i] = active & en_q[i] & ~sel_q[i];
    end

    assign fiq_any = |fiq_stat;

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic [WIDX_W-1:0] widx,
    input  logic [NSRC-1:0]   raw_stat,
    input  logic [NSRC-1:0]   irq_stat,
    input  logic [NSRC-1:0]   fiq_stat,
    input  logic [NSRC-1:0]   sel_q,
    input  logic [NSRC-1:0]   en_q,
    input  logic [NSRC-1:0]   sw_q,
    input  logic              prot_q,
    output logic [NSRC-1:0]   rdata
);

    localparam int unsigned ID_PAD = NSRC - 8;

    always_comb begin
        rdata = '0;
        if (widx >= W_ID_BASE) begin
            rdata = {{ID_PAD{1'b0}}, id_byte(widx[2:0])};
        end else begin
            case (widx)
                W_IRQ_STAT: rdata = irq_stat;
                W_FIQ_STAT: rdata = fiq_stat;
                W_RAW_STAT: rdata = raw_stat;
                W_SELECT:   rdata = sel_q;
                W_EN_SET:   rdata = en_q;
                W_SW_SET:   rdata = sw_q;
                W_PROT:     rdata = {{(NSRC-1){1'b0}}, prot_q};
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            wr_en,
    input  logic [11:0]     addr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] rdata,
    output logic [NSRC-1:0] irq_pend,
    output logic            fiq_req
);

    logic [WIDX_W-1:0] widx;
    logic [NSRC-1:0]   src_q, en_q, sw_q, sel_q;
    logic              prot_q;
    logic [NSRC-1:0]   raw_stat, irq_stat, fiq_stat;
    logic              fiq_any;
    logic              unused_lsb;

    assign widx       = addr[11:2];
    assign unused_lsb = ^addr[1:0];

    irq_route_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .wr_en(wr_en), .widx(widx), .wdata(wdata),
        .src_q(src_q), .en_q(en_q), .sw_q(sw_q), .sel_q(sel_q), .prot_q(prot_q)
    );

    irq_route_sort #(.NSRC(NSRC)) u_sort (
        .src_q(src_q), .sw_q(sw_q), .en_q(en_q), .sel_q(sel_q),
        .raw_stat(raw_stat), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
        .fiq_any(fiq_any)
    );

    irq_route_rdmux #(.NSRC(NSRC)) u_rdmux (
        .widx(widx), .raw_stat(raw_stat), .irq_stat(irq_stat),
        .fiq_stat(fiq_stat), .sel_q(sel_q), .en_q(en_q), .sw_q(sw_q),
        .prot_q(prot_q), .rdata(rdata)
    );

    assign irq_pend = irq_stat;
    assign fiq_req  = fiq_any;

    a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend & ~en_q) == '0);
    a_r2_not_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend & fiq_stat) == '0);
    a_r3_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req == (fiq_stat != '0));
    a_r1_raw_cover: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend | fiq_stat) & ~raw_stat) == '0);

endmodule

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;

    localparam int unsigned NSRC = 32;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SRC = 2'd2, OP_OUT = 2'd3;

    // {op, addr, data, expect, requirement number}
    localparam int NV = 46;
    localparam logic [85:0] TBL [NV] = '{
        {OP_SRC, 12'h000, 32'h0000_00F0, 32'h0,          8'd1},
        {OP_RD,  12'h008, 32'h0,          32'h0000_00F0, 8'd1},
        {OP_RD,  12'h000, 32'h0,          32'h0000_0000, 8'd2},
        {OP_OUT, 12'h000, 32'h0,          32'h0000_0000, 8'd2},
        {OP_WR,  12'h010, 32'h0000_0030, 32'h0,          8'd4},
        {OP_RD,  12'h010, 32'h0,          32'h0000_0030, 8'd4},
        {OP_RD,  12'h000, 32'h0,          32'h0000_0030, 8'd2},
        {OP_OUT, 12'h000, 32'h0,          32'h0000_0030, 8'd2},
        {OP_WR,  12'h010, 32'h0000_0300, 32'h0,          8'd4},
        {OP_RD,  12'h010, 32'h0,          32'h0000_0330, 8'd4},
        {OP_WR,  12'h014, 32'h0000_0010, 32'h0,          8'd4},
        {OP_RD,  12'h010, 32'h0,          32'h0000_0320, 8'd4},
        {OP_RD,  12'h000, 32'h0,          32'h0000_0020, 8'd2},
        {OP_WR,  12'h00C, 32'h0000_00A0, 32'h0,          8'd6},
        {OP_RD,  12'h00C, 32'h0,          32'h0000_00A0, 8'd6},
        {OP_RD,  12'h004, 32'h0,          32'h0000_00A0, 8'd3},
        {OP_RD,  12'h000, 32'h0,          32'h0000_0000, 8'd2},
        {OP_OUT, 12'h001, 32'h0,          32'h0000_0000, 8'd3},
        {OP_WR,  12'h018, 32'h0000_0300, 32'h0,          8'd5},
        {OP_RD,  12'h018, 32'h0,          32'h0000_0300, 8'd5},
        {OP_RD,  12'h008, 32'h0,          32'h0000_03F0, 8'd1},
        {OP_OUT, 12'h001, 32'h0,          32'h0000_0300, 8'd2},
        {OP_WR,  12'h01C, 32'h0000_0100, 32'h0,          8'd5},
        {OP_RD,  12'h018, 32'h0,          32'h0000_0200, 8'd5},
        {OP_RD,  12'h008, 32'h0,          32'h0000_02F0, 8'd1},
        {OP_WR,  12'h00C, 32'h0000_0000, 32'h0,          8'd6},
        {OP_OUT, 12'h000, 32'h0,          32'h0000_0220, 8'd3},
        {OP_WR,  12'h000, 32'hFFFF_FFFF, 32'h0,          8'd10},
        {OP_WR,  12'h004, 32'hFFFF_FFFF, 32'h0,          8'd10},
        {OP_WR,  12'h008, 32'hFFFF_FFFF, 32'h0,          8'd10},
        {OP_WR,  12'h040, 32'hFFFF_FFFF, 32'h0,          8'd10},
        {OP_WR,  12'hFE0, 32'hFFFF_FFFF, 32'h0,          8'd10},
        {OP_RD,  12'h010, 32'h0,          32'h0000_0320, 8'd10},
        {OP_RD,  12'h018, 32'h0,          32'h0000_0200, 8'd10},
        {OP_RD,  12'h00C, 32'h0,          32'h0000_0000, 8'd10},
        {OP_RD,  12'h000, 32'h0,          32'h0000_0220, 8'd10},
        {OP_RD,  12'h024, 32'h0,          32'h0000_0000, 8'd10},
        {OP_RD,  12'h100, 32'h0,          32'h0000_0000, 8'd10},
        {OP_RD,  12'hFDC, 32'h0,          32'h0000_0000, 8'd10},
        {OP_RD,  12'h014, 32'h0,          32'h0000_0000, 8'd10},
        {OP_WR,  12'h020, 32'hFFFF_FFFF, 32'h0,          8'd7},
        {OP_RD,  12'h020, 32'h0,          32'h0000_0001, 8'd7},
        {OP_WR,  12'h020, 32'h0000_0002, 32'h0,          8'd7},
        {OP_RD,  12'h020, 32'h0,          32'h0000_0000, 8'd7},
        {OP_SRC, 12'h000, 32'h0000_0000, 32'h0,          8'd1},
        {OP_OUT, 12'h000, 32'h0,          32'h0000_0200, 8'd1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_lvl = '0;
    logic            wr_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [NSRC-1:0] rdata, irq_pend;
    logic            fiq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_route_top #(.NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_pend(irq_pend), .fiq_req(fiq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 irq_pend in reset", irq_pend, 32'h0);
        check("R9 fiq_req in reset", {31'b0, fiq_req}, 32'h0);
        rst_n = 1'b1;
        do_read("R9 enable", 12'h010, 32'h0);
        do_read("R9 soft", 12'h018, 32'h0);
        do_read("R9 select", 12'h00C, 32'h0);
        do_read("R9 protection", 12'h020, 32'h0);

        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d step %0d", TBL[i][7:0], i);
            case (TBL[i][85:84])
                OP_WR:  do_write(TBL[i][83:72], TBL[i][71:40]);
                OP_RD:  do_read(rq, TBL[i][83:72], TBL[i][39:8]);
                OP_SRC: begin
                    @(negedge clk);
                    src_lvl = TBL[i][71:40];
                    @(negedge clk);
                end
                default: begin
                    @(negedge clk);
                    check(rq, irq_pend, TBL[i][39:8]);
                    check(rq, {31'b0, fiq_req}, {31'b0, TBL[i][72]});
                end
            endcase
        end

        // R8: identification bytes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] idv [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            do_read("R8 id byte", 12'hFE0 + 12'(4 * k), {24'h0, idv[k]});
        end

        // R11: one-cycle latency from src_lvl to outputs (enable = 0x321 after write)
        do_write(12'h010, 32'h0000_0001);
        @(negedge clk);
        src_lvl = 32'h0000_0001;
        #1;
        check("R11 before edge", irq_pend, 32'h0000_0200);
        @(posedge clk);
        #1;
        check("R11 after edge", irq_pend, 32'h0000_0201);

        // R3: fast line ignores enable; bit 4 is cleared in enable
        do_write(12'h00C, 32'h0000_0010);
        @(negedge clk);
        src_lvl = 32'h0000_0011;
        @(negedge clk);
        check("R3 fiq without enable", {31'b0, fiq_req}, 32'h1);
        do_read("R3 fiq status", 12'h004, 32'h0000_0010);

        // R9: reset mid-run with a source held high
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 irq_pend held low", irq_pend, 32'h0);
        check("R9 fiq_req held low", {31'b0, fiq_req}, 32'h0);
        rst_n = 1'b1;
        do_read("R9 enable after reset", 12'h010, 32'h0);
        do_read("R9 select after reset", 12'h00C, 32'h0);
        do_read("R9 raw after reset", 12'h008, 32'h0000_0011);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule